// File: doc/BRIEF.md
# Stride Data Prefetcher

This block watches the loads a core executes, each reported as a program counter and a data address, and learns which loads walk through memory with a fixed spacing. When a load has repeated the same nonzero spacing it issues a prefetch for the address that load is expected to touch next. That way the line can be on its way before the load asks for it.

Loads that have not yet shown a fixed spacing live in a four-entry candidate table. A candidate that shows the same address difference twice in a row is moved into a four-entry confirmed table and removed from the candidate table. Both tables replace their least recently observed entry when full. Each confirmed load has at most one prefetch in flight. It waits for a fill acknowledge carrying the prefetched address before it may issue again. Requests go out through a single registered valid/ready port. The port is meant for a memory arbiter that ranks the prefetcher third and grants it only when the two higher requesters are idle, so a request may wait any number of cycles.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset no request is offered and both tables are empty, so the first and second observation of any load issue no prefetch.
- R2: A load is confirmed only when two successive differences between its observed addresses are equal, that is, on its third observation with constant nonzero spacing. Ascending and descending spacings are both confirmed.
- R3: The prefetch address is the confirming observation's address plus the stride, modulo 2^AW. The request becomes valid one clock after the edge that captured that observation.
- R4: A valid request keeps its address unchanged until the edge at which pf_req_ready is high, and it is withdrawn after that edge unless another is pending.
- R5: After a load's prefetch is granted, further matching observations of that load issue nothing until a fill acknowledge with the same address arrives. The first matching observation after that issues again.
- R6: An observation whose difference differs from the stored stride issues nothing and makes that difference the new stride. Prefetching resumes on the next observation that repeats it.
- R7: A load whose address difference is zero never issues a prefetch.
- R8: Up to four confirmed loads prefetch independently. Prefetches pending at once are offered one at a time until all have been granted. A program counter is never held in both tables.
- R9: When the candidate table is full, a new load replaces the least recently observed candidate, which must then train from the start.
- R10: When the confirmed table is full, a newly confirmed load replaces the least recently observed confirmed load. That load must retrain, while the surviving loads keep prefetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | A load observation is presented this cycle |
| obs_pc | input | PC_W | Program counter of the observed load |
| obs_addr | input | AW | Data address of the observed load |
| pf_req_valid | output | 1 | Prefetch request offered to the memory arbiter |
| pf_req_addr | output | AW | Address to prefetch |
| pf_req_ready | input | 1 | Arbiter grant; transfer when high together with valid |
| fill_ack_valid | input | 1 | A prefetch fill has completed |
| fill_ack_addr | input | AW | Address of the completed fill |

## Verification
A corrupted stride or last-address field shows up on the next matching observation. The request then appears one clock later with a wrong address, or it does not appear when it should. A stuck outstanding state shows as silence after a fill acknowledge. Wrong replacement order shows only a few observations later, when a load that should have survived must retrain or an evicted load prefetches too early. The bench therefore checks each request in the cycle it is due, checks the absence of one in that same cycle, and replays evicted loads to observe which entry was lost.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // Prefetch progress of one confirmed-table entry
  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,  // may issue on the next matching observation
    PF_WAIT = 2'd1,  // prefetch computed, waiting for the output slot
    PF_INFL = 2'd2   // handed to the arbiter, waiting for fill acknowledge
  } pf_state_e;
endpackage

// File: rtl/spf_pick.sv
// Lowest-index selector over a request vector.
module spf_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/spf_lru.sv
// Recency ranking: rank 0 is most recently touched, rank N-1 is the victim.
module spf_lru #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] rank [N];
  logic [N-1:0]  oldest_vec;
  logic          oldest_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank[i] <= i[IW-1:0];
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (i[IW-1:0] == touch_idx)          rank[i] <= '0;
        else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest_vec[g] = (rank[g] == IW'(N - 1));
  end

  spf_pick #(.N(N), .IW(IW)) u_old (.req(oldest_vec), .any(oldest_any), .idx(oldest_idx));

  // R9 R10: the ranks stay a permutation, so exactly one victim exists
  always @(posedge clk) begin
    if (rst_n) begin
      lru_single_victim_chk: assert ($countones(oldest_vec) == 1 && oldest_any)
        else $error("lru: victim not unique");
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import spf_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int AW      = 32,
  parameter int ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            obs_valid,
  input  logic [PC_W-1:0] obs_pc,
  input  logic [AW-1:0]   obs_addr,
  output logic            pf_req_valid,
  output logic [AW-1:0]   pf_req_addr,
  input  logic            pf_req_ready,
  input  logic            fill_ack_valid,
  input  logic [AW-1:0]   fill_ack_addr
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Address arithmetic, wrapping modulo 2^AW
  function automatic logic [AW-1:0] addr_gap(input logic [AW-1:0] now, input logic [AW-1:0] prev);
    return now - prev;
  endfunction
  function automatic logic [AW-1:0] predict(input logic [AW-1:0] now, input logic [AW-1:0] gap);
    return now + gap;
  endfunction

  // Candidate table
  logic            cand_v    [ENTRIES];
  logic [PC_W-1:0] cand_pc   [ENTRIES];
  logic [AW-1:0]   cand_last [ENTRIES];
  logic [AW-1:0]   cand_gap  [ENTRIES];
  logic            cand_hasg [ENTRIES];
  // Confirmed table
  logic            str_v     [ENTRIES];
  logic [PC_W-1:0] str_pc    [ENTRIES];
  logic [AW-1:0]   str_last  [ENTRIES];
  logic [AW-1:0]   str_gap   [ENTRIES];
  pf_state_e       str_st    [ENTRIES];
  logic [AW-1:0]   str_pf    [ENTRIES];
  // Output slot
  logic            out_v;
  logic [AW-1:0]   out_addr;

  logic [ENTRIES-1:0] c_hit_vec, s_hit_vec, c_free_vec, s_free_vec, s_wait_vec, dup_vec;
  logic          c_hit, s_hit, c_free_any, s_free_any, wait_any;
  logic [IW-1:0] c_hit_idx, s_hit_idx, c_free_idx, s_free_idx, wait_idx;
  logic [IW-1:0] c_old_idx, s_old_idx, c_alloc_idx, s_alloc_idx, issue_idx, c_touch_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
    assign c_hit_vec[g]  = obs_valid && cand_v[g] && (cand_pc[g] == obs_pc);
    assign s_hit_vec[g]  = obs_valid && str_v[g] && (str_pc[g] == obs_pc);
    assign c_free_vec[g] = !cand_v[g];
    assign s_free_vec[g] = !str_v[g];
    assign s_wait_vec[g] = str_v[g] && (str_st[g] == PF_WAIT);
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      dup_vec[i] = 1'b0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (str_v[i] && cand_v[j] && str_pc[i] == cand_pc[j]) dup_vec[i] = 1'b1;
      end
    end
  end

  spf_pick #(.N(ENTRIES), .IW(IW)) u_chit  (.req(c_hit_vec),  .any(c_hit),      .idx(c_hit_idx));
  spf_pick #(.N(ENTRIES), .IW(IW)) u_shit  (.req(s_hit_vec),  .any(s_hit),      .idx(s_hit_idx));
  spf_pick #(.N(ENTRIES), .IW(IW)) u_cfree (.req(c_free_vec), .any(c_free_any), .idx(c_free_idx));
  spf_pick #(.N(ENTRIES), .IW(IW)) u_sfree (.req(s_free_vec), .any(s_free_any), .idx(s_free_idx));
  spf_pick #(.N(ENTRIES), .IW(IW)) u_wait  (.req(s_wait_vec), .any(wait_any),   .idx(wait_idx));

  // Named internal events
  logic [AW-1:0] gap_s, gap_c, issue_addr;
  logic          stride_match, promote, new_cand, issue_fire, issue_on_busy;
  logic          slot_load, cand_touch, str_touch;

  always_comb begin
    gap_s        = addr_gap(obs_addr, str_last[s_hit_idx]);
    gap_c        = addr_gap(obs_addr, cand_last[c_hit_idx]);
    stride_match = s_hit && (gap_s == str_gap[s_hit_idx]);
    promote      = !s_hit && c_hit && cand_hasg[c_hit_idx] && (gap_c == cand_gap[c_hit_idx]);
    new_cand     = obs_valid && !s_hit && !c_hit;
    s_alloc_idx  = s_free_any ? s_free_idx : s_old_idx;
    c_alloc_idx  = c_free_any ? c_free_idx : c_old_idx;
    issue_idx    = s_hit ? s_hit_idx : s_alloc_idx;
    issue_fire   = (stride_match && gap_s != '0 && str_st[s_hit_idx] == PF_IDLE) ||
                   (promote && gap_c != '0);
    issue_on_busy = issue_fire && s_hit && (str_st[s_hit_idx] != PF_IDLE);
    issue_addr   = predict(obs_addr, s_hit ? gap_s : gap_c);
    slot_load    = wait_any && (!out_v || pf_req_ready);
    str_touch    = s_hit || promote;
    cand_touch   = (c_hit && !promote && !s_hit) || new_cand;
    c_touch_idx  = c_hit ? c_hit_idx : c_alloc_idx;
  end

  spf_lru #(.N(ENTRIES), .IW(IW)) u_clru (.clk(clk), .rst_n(rst_n), .touch(cand_touch),
    .touch_idx(c_touch_idx), .oldest_idx(c_old_idx));
  spf_lru #(.N(ENTRIES), .IW(IW)) u_slru (.clk(clk), .rst_n(rst_n), .touch(str_touch),
    .touch_idx(issue_idx), .oldest_idx(s_old_idx));

  // Confirmed table and output slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_addr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        str_v[i] <= 1'b0; str_pc[i] <= '0; str_last[i] <= '0;
        str_gap[i] <= '0; str_st[i] <= PF_IDLE; str_pf[i] <= '0;
      end
    end else begin
      if (out_v && pf_req_ready) out_v <= 1'b0;
      if (slot_load) begin
        out_v            <= 1'b1;
        out_addr         <= str_pf[wait_idx];
        str_st[wait_idx] <= PF_INFL;
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_ack_valid && str_st[i] == PF_INFL && str_pf[i] == fill_ack_addr)
          str_st[i] <= PF_IDLE;
      end
      if (s_hit) begin
        str_last[s_hit_idx] <= obs_addr;
        str_gap[s_hit_idx]  <= gap_s;
      end
      if (promote) begin
        str_v[s_alloc_idx]    <= 1'b1;
        str_pc[s_alloc_idx]   <= obs_pc;
        str_last[s_alloc_idx] <= obs_addr;
        str_gap[s_alloc_idx]  <= gap_c;
        str_st[s_alloc_idx]   <= PF_IDLE;
      end
      if (issue_fire) begin
        str_st[issue_idx] <= PF_WAIT;
        str_pf[issue_idx] <= issue_addr;
      end
    end
  end

  // Candidate table
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cand_v[i] <= 1'b0; cand_pc[i] <= '0; cand_last[i] <= '0;
        cand_gap[i] <= '0; cand_hasg[i] <= 1'b0;
      end
    end else if (promote) begin
      cand_v[c_hit_idx] <= 1'b0;
    end else if (c_hit && !s_hit) begin
      cand_last[c_hit_idx] <= obs_addr;
      cand_gap[c_hit_idx]  <= gap_c;
      cand_hasg[c_hit_idx] <= 1'b1;
    end else if (new_cand) begin
      cand_v[c_alloc_idx]    <= 1'b1;
      cand_pc[c_alloc_idx]   <= obs_pc;
      cand_last[c_alloc_idx] <= obs_addr;
      cand_hasg[c_alloc_idx] <= 1'b0;
    end
  end

  assign pf_req_valid = out_v;
  assign pf_req_addr  = out_addr;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid && !pf_req_ready |=> pf_req_valid && $stable(pf_req_addr))
    else $error("request changed before grant");
  // R7
  zero_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> issue_addr != obs_addr)
    else $error("prefetch issued for zero stride");
  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_on_busy)
    else $error("second prefetch for a busy entry");
  // R8
  no_dup_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_vec == '0)
    else $error("pc held in both tables");
  // R8
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_hit_vec) && $onehot0(c_hit_vec))
    else $error("multiple table hits");
  // R3
  slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_load |=> pf_req_valid)
    else $error("loaded slot not offered");
endmodule

// File: tb/stride_prefetcher_tb_top.sv
module stride_prefetcher_tb_top;
  localparam int PC_W = 16;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            obs_valid = 1'b0;
  logic [PC_W-1:0] obs_pc = '0;
  logic [AW-1:0]   obs_addr = '0;
  logic            pf_req_valid;
  logic [AW-1:0]   pf_req_addr;
  logic            pf_req_ready = 1'b0;
  logic            fill_ack_valid = 1'b0;
  logic [AW-1:0]   fill_ack_addr = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stride_prefetcher #(.PC_W(PC_W), .AW(AW), .ENTRIES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_pc(obs_pc), .obs_addr(obs_addr),
    .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr), .pf_req_ready(pf_req_ready),
    .fill_ack_valid(fill_ack_valid), .fill_ack_addr(fill_ack_addr));

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic observe(input logic [PC_W-1:0] pc, input logic [AW-1:0] addr);
    @(negedge clk);
    obs_valid = 1'b1; obs_pc = pc; obs_addr = addr;
    @(negedge clk);
    obs_valid = 1'b0;
  endtask

  task automatic grant();
    pf_req_ready = 1'b1;
    @(negedge clk);
    pf_req_ready = 1'b0;
  endtask

  task automatic ack(input logic [AW-1:0] addr);
    fill_ack_valid = 1'b1; fill_ack_addr = addr;
    @(negedge clk);
    fill_ack_valid = 1'b0;
  endtask

  // Called right after observe: checks the cycle after the capturing edge
  task automatic expect_none(input string req);
    @(negedge clk);
    check(!pf_req_valid, req, {31'd0, pf_req_valid}, '0);
  endtask

  task automatic expect_req(input string req, input logic [AW-1:0] exp, input bit do_ack);
    @(negedge clk);
    check(pf_req_valid && pf_req_addr == exp, req, pf_req_addr, exp);
    grant();
    if (do_ack) ack(exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!pf_req_valid, "R1 reset", {31'd0, pf_req_valid}, '0);
  endtask

  task automatic t_confirm();
    logic [AW-1:0] a = 32'h1000_0000;
    logic [AW-1:0] b = 32'h2000_0100;
    observe(16'h0050, a);          expect_none("R1 first obs");
    observe(16'h0050, a + 32'h40); expect_none("R2 second obs");
    observe(16'h0050, a + 32'h80); expect_req("R3 ascending", a + 32'hC0, 1'b1);
    observe(16'h0051, b);          expect_none("R1 first obs desc");
    observe(16'h0051, b - 32'd4);  expect_none("R2 second obs desc");
    observe(16'h0051, b - 32'd8);  expect_req("R2 descending", b - 32'd12, 1'b1);
  endtask

  task automatic t_hold();
    logic [AW-1:0] a = 32'h3000_0000;
    observe(16'h0060, a); observe(16'h0060, a + 32'h20); observe(16'h0060, a + 32'h40);
    @(negedge clk);
    check(pf_req_valid && pf_req_addr == a + 32'h60, "R4 offered", pf_req_addr, a + 32'h60);
    repeat (5) begin
      @(negedge clk);
      check(pf_req_valid && pf_req_addr == a + 32'h60, "R4 held", pf_req_addr, a + 32'h60);
    end
    grant();
    check(!pf_req_valid, "R4 withdrawn", {31'd0, pf_req_valid}, '0);
    ack(a + 32'h60);
  endtask

  task automatic t_outstanding();
    logic [AW-1:0] a = 32'h4000_0000;
    observe(16'h0070, a); observe(16'h0070, a + 32'h10);
    observe(16'h0070, a + 32'h20); expect_req("R5 first", a + 32'h30, 1'b0);
    observe(16'h0070, a + 32'h30); expect_none("R5 busy");
    ack(a + 32'h30);
    observe(16'h0070, a + 32'h40); expect_req("R5 after ack", a + 32'h50, 1'b1);
  endtask

  task automatic t_mismatch();
    logic [AW-1:0] a = 32'h5000_0000;
    observe(16'h0200, a); observe(16'h0200, a + 32'd16);
    observe(16'h0200, a + 32'd32);  expect_req("R6 trained", a + 32'd48, 1'b1);
    observe(16'h0200, a + 32'd100); expect_none("R6 mismatch");
    observe(16'h0200, a + 32'd168); expect_req("R6 retrained", a + 32'd236, 1'b1);
  endtask

  task automatic t_zero();
    for (int k = 0; k < 5; k++) begin
      observe(16'h0300, 32'h6000_0040);
      expect_none("R7 zero stride");
    end
  endtask

  task automatic t_cand_lru();
    logic [AW-1:0] a0 = 32'h7000_0000;
    logic [AW-1:0] a1 = 32'h7100_0000;
    observe(16'h0400, a0);
    observe(16'h0401, a1);
    observe(16'h0402, 32'h7200_0000);
    observe(16'h0403, 32'h7300_0000);
    observe(16'h0404, 32'h7400_0000);
    observe(16'h0401, a1 + 32'h8);  expect_none("R9 survivor delta");
    observe(16'h0401, a1 + 32'h10); expect_req("R9 survivor kept", a1 + 32'h18, 1'b1);
    observe(16'h0400, a0 + 32'h8);  expect_none("R9 evicted restarts");
    observe(16'h0400, a0 + 32'h10); expect_none("R9 evicted no early prefetch");
    observe(16'h0400, a0 + 32'h18); expect_req("R9 evicted retrained", a0 + 32'h20, 1'b1);
  endtask

  logic [AW-1:0] lpos [5];
  logic [AW-1:0] lstr [5];

  task automatic t_multi_and_str_lru();
    logic [AW-1:0] exp [4];
    bit [3:0] seen = '0;
    for (int k = 0; k < 5; k++) begin
      lpos[k] = 32'h8000_0000 + k * 32'h0010_0000;
      lstr[k] = (k + 1) * 8;
    end
    for (int k = 0; k < 4; k++) begin
      observe(16'h0100 + k, lpos[k]);
      observe(16'h0100 + k, lpos[k] + lstr[k]);
      lpos[k] = lpos[k] + 2 * lstr[k];
      observe(16'h0100 + k, lpos[k]);
      expect_req("R8 train", lpos[k] + lstr[k], 1'b1);
    end
    for (int k = 0; k < 4; k++) begin
      lpos[k] = lpos[k] + lstr[k];
      exp[k] = lpos[k] + lstr[k];
      observe(16'h0100 + k, lpos[k]);
    end
    for (int n = 0; n < 4; n++) begin
      bit hit = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (pf_req_valid && pf_req_addr == exp[k] && !seen[k]) begin
          seen[k] = 1'b1; hit = 1'b1;
        end
      end
      check(hit, "R8 concurrent", pf_req_addr, exp[n]);
      ack(pf_req_addr);
      grant();
    end
    check(seen == 4'hF, "R8 all offered", {28'd0, seen}, 32'hF);
    // fresh load evicts the least recently observed confirmed load (pc 0x100)
    observe(16'h0104, lpos[4]);
    observe(16'h0104, lpos[4] + lstr[4]);
    lpos[4] = lpos[4] + 2 * lstr[4];
    observe(16'h0104, lpos[4]);
    expect_req("R10 new confirmed", lpos[4] + lstr[4], 1'b1);
    lpos[1] = lpos[1] + lstr[1];
    observe(16'h0101, lpos[1]);
    expect_req("R10 survivor", lpos[1] + lstr[1], 1'b1);
    lpos[0] = lpos[0] + lstr[0];
    observe(16'h0100, lpos[0]); expect_none("R10 evicted first");
    lpos[0] = lpos[0] + lstr[0];
    observe(16'h0100, lpos[0]); expect_none("R10 evicted second");
    lpos[0] = lpos[0] + lstr[0];
    observe(16'h0100, lpos[0]);
    expect_req("R10 evicted retrained", lpos[0] + lstr[0], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_confirm();
    t_hold();
    t_outstanding();
    t_mismatch();
    t_zero();
    t_cand_lru();
    t_multi_and_str_lru();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule